// File: doc/BRIEF.md
# Command-Queued SPI Master Sequencer

This block is an SPI master that walks a list of queued transfers on its own. Software fills a sixteen-entry command memory and a sixteen-entry transmit memory through a small register write port. It also sets a global bit count, a clock divider, two delay counts and the idle level of the chip-select lines. Then it pulses `start` with a first and a last entry index. Each command byte chooses the chip-select pattern for its entry, the transfer width, an optional chip-select-to-clock lead delay, an optional trailing delay, and whether the chip selects stay asserted into the following entry.

The shifter runs in mode 0: MSB first, MOSI changes on falling SCK, and MISO is sampled on rising SCK. Every SCK half period lasts `div+1` clock cycles. Each received word is stored at its entry's index in a receive memory, which can be read at any time through a combinational read port. A one-cycle `done` pulse marks the end of the queue.

Top module: `spi_cmd_queue`

## Requirements
- R1: After reset, `cs` is 4'b1111 (the idle level resets to 1), `sck` is 0, `mosi` is 0 and `done` is 0.
- R2: While an entry is active, `cs[3:0]` equals command bits 3..0 of that entry, undecoded. At all other times every `cs` line equals the programmed idle bit.
- R3: Command bit 6 = 0 gives an 8-bit transfer. Bit 6 = 1 uses the bit-count field: values 8..15 mean that many bits, and 0..7 mean 16 bits.
- R4: Data shifts MSB first from the low `n` bits of the transmit word. MOSI changes only on falling SCK, MISO is sampled on rising SCK, and each SCK level lasts `div+1` cycles.
- R5: With command bit 4 = 0, the first rising SCK comes one half period after the chip selects turn active. With bit 4 = 1, it comes `lead+1` half periods after.
- R6: With command bit 5 = 1, the last falling SCK is followed by `trail+1` half periods with SCK low and chip selects held before the entry ends. With bit 5 = 0, the entry ends at the last falling SCK.
- R7: When a non-final entry ends, command bit 7 = 1 loads the next entry at once, with no idle gap on `cs`. Bit 7 = 0 drives `cs` to idle for one half period first.
- R8: Entries run from `start_idx` to `end_idx` inclusive. When the last one ends, `done` is high for exactly one cycle and `cs` returns to idle regardless of that entry's bit 7.
- R9: Each entry's received bits are written into the receive memory at the entry's index, right-justified and zero-extended.
- R10: A `start` pulse while a queue is running has no effect on the sequence.
- R11: Writes use `wr_sel`: 0 = command byte `wr_data[7:0]` at `wr_addr`; 1 = transmit word at `wr_addr`; 2 = bit count `wr_data[3:0]`; 3 = divider; 4 = lead count; 5 = trail count; 6 = idle level `wr_data[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register/memory write strobe |
| wr_sel | input | 3 | Write target select |
| wr_addr | input | 4 | Entry index for memory writes |
| wr_data | input | 16 | Write data |
| start | input | 1 | Begin running the queue |
| start_idx | input | 4 | First entry to run |
| end_idx | input | 4 | Last entry to run |
| done | output | 1 | One-cycle pulse at queue end |
| rd_addr | input | 4 | Receive memory read index |
| rd_data | output | 16 | Receive memory read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select lines |

## Verification
Ending one entry and loading the next can happen on the same clock edge. When a continuous entry finishes without a trailing delay, its received word is committed on the same edge that fetches the following command and its first MOSI bit. A separate stray `start` pulse is also injected into a running queue. The bench chains continuous entries and compares `cs`, `sck`, `mosi` and `done` against its timeline model on every clock, so any one-cycle gap or slip shows up. It then reads back both received words to confirm that neither was lost or shifted.

// File: rtl/spi_cmd_queue.sv
module spi_cmd_queue #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  parameter int DLY_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        start,
  input  logic [3:0]  start_idx,
  input  logic [3:0]  end_idx,
  output logic        done,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP} st_t;

  logic [7:0]       cmd_ram [DEPTH];
  logic [15:0]      tx_ram  [DEPTH];
  logic [15:0]      rx_ram  [DEPTH];
  logic [3:0]       bit_cfg;
  logic [DIV_W-1:0] div_cfg, div_cnt;
  logic [DLY_W-1:0] lead_cfg, trail_cfg, dcnt;
  logic             cs_idle, cs_on, sck_r, done_r;
  st_t              st;
  logic [AW-1:0]    idx, last_idx, ld_idx;
  logic [7:0]       cmd_r, ld_cmd;
  logic [15:0]      tx_sh, rx_sh;
  logic [4:0]       bits, ld_n;
  logic             tick, go, fin, is_last, do_load;

  assign tick    = (st != S_IDLE) && (div_cnt == div_cfg);
  assign go      = (st == S_IDLE) && start;
  assign is_last = (idx == last_idx);
  assign fin     = (tick && st == S_SHIFT && sck_r && bits == 5'd1 && !cmd_r[5]) ||
                   (tick && st == S_TRAIL && dcnt == '0);
  assign ld_idx  = go ? start_idx[AW-1:0] : idx + 1'b1;
  assign ld_cmd  = cmd_ram[ld_idx];
  assign ld_n    = ld_cmd[6] ? (bit_cfg[3] ? {1'b0, bit_cfg} : 5'd16) : 5'd8;
  assign do_load = go || (tick && st == S_GAP) || (fin && !is_last && cmd_r[7]);

  assign sck     = sck_r;
  assign mosi    = tx_sh[15];
  assign cs      = cs_on ? cmd_r[3:0] : {4{cs_idle}};
  assign done    = done_r;
  assign rd_data = rx_ram[rd_addr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == 3'd0) cmd_ram[wr_addr[AW-1:0]] <= wr_data[7:0];
    if (wr_en && wr_sel == 3'd1) tx_ram[wr_addr[AW-1:0]]  <= wr_data;
    if (fin) rx_ram[idx] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cfg <= '0; div_cfg <= '0; lead_cfg <= '0; trail_cfg <= '0; cs_idle <= 1'b1;
      div_cnt <= '0; dcnt <= '0; st <= S_IDLE; idx <= '0; last_idx <= '0;
      cmd_r <= '0; tx_sh <= '0; rx_sh <= '0; bits <= '0;
      cs_on <= 1'b0; sck_r <= 1'b0; done_r <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          3'd2: bit_cfg   <= wr_data[3:0];
          3'd3: div_cfg   <= wr_data[DIV_W-1:0];
          3'd4: lead_cfg  <= wr_data[DLY_W-1:0];
          3'd5: trail_cfg <= wr_data[DLY_W-1:0];
          3'd6: cs_idle   <= wr_data[0];
          default: ;
        endcase
      end
      div_cnt <= (st == S_IDLE || tick) ? '0 : div_cnt + 1'b1;
      done_r  <= fin && is_last;
      if (do_load) begin
        if (go) last_idx <= end_idx[AW-1:0];
        idx   <= ld_idx;
        cmd_r <= ld_cmd;
        cs_on <= 1'b1;
        tx_sh <= tx_ram[ld_idx] << (5'd16 - ld_n);
        bits  <= ld_n;
        rx_sh <= '0;
        sck_r <= 1'b0;
        dcnt  <= ld_cmd[4] ? lead_cfg : '0;
        st    <= S_LEAD;
      end else if (fin) begin
        cs_on <= 1'b0;
        sck_r <= 1'b0;
        st    <= is_last ? S_IDLE : S_GAP;
      end else if (tick) begin
        case (st)
          S_LEAD:
            if (dcnt == '0) begin
              st    <= S_SHIFT;
              sck_r <= 1'b1;
              rx_sh <= {rx_sh[14:0], miso};
            end else dcnt <= dcnt - 1'b1;
          S_SHIFT:
            if (!sck_r) begin
              sck_r <= 1'b1;
              rx_sh <= {rx_sh[14:0], miso};
            end else begin
              sck_r <= 1'b0;
              if (bits == 5'd1) begin
                st   <= S_TRAIL;
                dcnt <= trail_cfg;
              end else begin
                bits  <= bits - 5'd1;
                tx_sh <= tx_sh << 1;
              end
            end
          S_TRAIL: dcnt <= dcnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r4_sck_only_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SHIFT) |-> !sck);
  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));
  a_r2_cs_steady_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st == S_SHIFT)) |-> $stable(cs));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs == {4{cs_idle}} && st == S_IDLE));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE && !fin) |=> (st != S_IDLE && $stable(last_idx)));
endmodule

// File: tb/tb_spi_cmd_queue.sv
module tb_spi_cmd_queue;
  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [2:0] wr_sel = 0;
  logic [3:0] wr_addr = 0, start_idx = 0, end_idx = 0, rd_addr = 0, cs;
  logic [15:0] wr_data = 0, rd_data;
  logic done, sck, mosi, miso;
  int total = 0, bad = 0;

  logic [7:0]  m_cmd [16];
  logic [15:0] m_tx  [16];
  logic [15:0] m_rx  [16];
  int m_bc = 0, m_div = 0, m_lead = 0, m_trail = 0;
  logic m_idle = 1;
  logic exp_act = 0, exp_sck = 0, exp_mosi = 0, exp_done = 0, cmp_on = 0;
  logic [3:0] exp_csv = 0;

  always #2 clk = ~clk;
  assign miso = ~mosi;

  spi_cmd_queue dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .start_idx(start_idx),
    .end_idx(end_idx), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs(cs));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 cs", {28'd0, cs}, {28'd0, exp_act ? exp_csv : {4{m_idle}}});
    chk("R4 sck", {31'd0, sck}, {31'd0, exp_sck});
    chk("R4 mosi", {31'd0, mosi}, {31'd0, exp_mosi});
    chk("R8 done", {31'd0, done}, {31'd0, exp_done});
  end

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel[2:0]; wr_addr = addr[3:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 0;
    case (sel)
      0: m_cmd[addr] = data[7:0];
      1: m_tx[addr] = data[15:0];
      2: m_bc = data & 15;
      3: m_div = data & 255;
      4: m_lead = data & 255;
      5: m_trail = data & 255;
      6: m_idle = data[0];
      default: ;
    endcase
  endtask

  function automatic int nbits(input logic [7:0] c);
    return c[6] ? ((m_bc >= 8) ? m_bc : 16) : 8;
  endfunction

  task automatic ticks(input int k);
    repeat (k * (m_div + 1)) @(posedge clk);
    #1;
  endtask

  task automatic load(input int i);
    exp_act = 1; exp_csv = m_cmd[i][3:0]; exp_sck = 0;
    exp_mosi = m_tx[i][nbits(m_cmd[i]) - 1];
  endtask

  task automatic run_queue(input int s, input int e, input bit stray);
    int i, n;
    @(negedge clk);
    start_idx = s[3:0]; end_idx = e[3:0]; start = 1;
    @(posedge clk); #1; start = 0;
    if (stray) fork
      begin
        repeat (7) @(negedge clk);
        start = 1; start_idx = 4'd2; end_idx = 4'd2;   // R10 stray request
        @(negedge clk); start = 0;
      end
    join_none
    i = s;
    load(i);
    forever begin
      n = nbits(m_cmd[i]);
      for (int b = n - 1; b >= 0; b--) begin
        ticks((b == n - 1) ? (m_cmd[i][4] ? m_lead + 1 : 1) : 1);   // R5 lead
        exp_sck = 1;
        ticks(1);
        exp_sck = 0;
        if (b > 0) exp_mosi = m_tx[i][b-1];
      end
      if (m_cmd[i][5]) ticks(m_trail + 1);                         // R6 trail
      m_rx[i] = ~m_tx[i] & 16'((32'd1 << n) - 1);
      if (i == e) begin
        exp_act = 0; exp_done = 1;
        @(posedge clk); #1; exp_done = 0;
        break;
      end else if (m_cmd[i][7]) begin                              // R7 continuous
        i++; load(i);
      end else begin
        exp_act = 0; ticks(1); i++; load(i);
      end
    end
  endtask

  task automatic check_rx(input int s, input int e);
    for (int i = s; i <= e; i++) begin
      @(negedge clk); rd_addr = i[3:0]; #1;
      chk("R9 rx word", {16'd0, rd_data}, {16'd0, m_rx[i]});
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs", {28'd0, cs}, 32'hF);
    chk("R1 sck", {31'd0, sck}, 0);
    chk("R1 mosi", {31'd0, mosi}, 0);
    chk("R1 done", {31'd0, done}, 0);
    rst_n = 1;
    cmp_on = 1;
    // R11 config, R3 programmed width 12
    wr(3, 0, 1); wr(2, 0, 12); wr(4, 0, 2); wr(5, 0, 3); wr(6, 0, 1);
    wr(0, 0, 'h0E); wr(1, 0, 'h00A5);
    wr(0, 1, 'hDD); wr(1, 1, 'h0F3C);
    wr(0, 2, 'h6B); wr(1, 2, 'h1234);
    wr(0, 3, 'h87); wr(1, 3, 'h005A);
    run_queue(0, 3, 1);          // R7 continuous handover, R8 last cont ignored, R10
    check_rx(0, 3);
    repeat (5) @(negedge clk);
    // R2 idle level low, R3 bit count 0 -> 16, divider 0
    wr(3, 0, 0); wr(6, 0, 0); wr(2, 0, 0);
    wr(0, 5, 'hC3); wr(1, 5, 'hC3A5);
    wr(0, 6, 'h4C); wr(1, 6, 'h8001);
    run_queue(5, 6, 0);
    check_rx(5, 6);
    // R3 bit count 5 -> 16; R5/R6 zero delays
    wr(2, 0, 5); wr(4, 0, 0); wr(5, 0, 0);
    wr(0, 9, 'h79); wr(1, 9, 'h3C96);
    run_queue(9, 9, 0);
    check_rx(9, 9);
    // R3 bit count 15, slower divider
    wr(2, 0, 15); wr(3, 0, 2); wr(6, 0, 1);
    wr(0, 10, 'hC2); wr(1, 10, 'h7FFF);
    run_queue(10, 10, 0);
    check_rx(10, 10);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule